// File: doc/BRIEF.md
# Dual-Edge Period and Pulse Capture Unit

This block measures the period and pulse width of three independent digital inputs against one shared free-running timestamp counter. Each input is synchronised with two flops, and every change of level on it is detected as either a rising or a falling edge. While a channel is active, each edge stores the current counter value. The first edge also records whether it was falling.

When the fourth edge arrives, the channel computes a period and a pulse width from the four timestamps. Which timestamps are subtracted depends on the polarity of the first edge and on the channel's inversion setting. The channel then sets its sticky interrupt bit and queues a one-cycle report that carries the channel number and both values. A one-shot channel switches itself off after its result. A continuous channel starts a fresh four-edge window with the next edge.

Software starts and stops channels with pulses, clears interrupt bits by writing ones, and selects per channel whether the period and the pulse width are reported.

Top module: `pulse_period_capture`

## Requirements
- R1: `ts_now` is 0 after reset, advances by exactly 1 on each clock in which `tmr_en` is 1, and holds its value while `tmr_en` is 0.
- R2: A `start` pulse on an idle channel makes that channel's `chan_on` bit 1 on the next clock and restarts its window at the first sample. A `stop` pulse clears `chan_on` on the next clock, takes priority over `start`, and discards any samples already collected.
- R3: A `start` pulse on a channel that is already active raises `busy_err` for exactly one cycle, on the next clock, and leaves the channel's collection undisturbed.
- R4: With `inv` at 0, if the first sample is rising: period = t2 − t0 and pulse = t1 − t0. If it is falling: period = t3 − t1 and pulse = t2 − t1. t0..t3 are the counter values of four consecutive edges, and all subtraction is modulo 2^CW.
- R5: With `inv` at 1, the edge roles swap. A falling first sample gives period = t2 − t0 and pulse = t1 − t0. A rising first sample gives period = t3 − t1 and pulse = t2 − t1.
- R6: Bit n of `irq_sts` (n = channel 0..2) is set when channel n completes a result and stays set until a clock with `clr_wr` = 1 and `clr_mask` bit n = 1. Mask bits at 0 clear nothing, and a completion in the same clock wins over the clear.
- R7: Each completed result is reported exactly once with a one-cycle `res_valid` pulse and its channel number in `res_ch`. When several unreported results are pending, the lowest-numbered channel is reported first, one per cycle.
- R8: `res_period` reads 0 when `per_en` for the reported channel is 0, and `res_pulse` reads 0 when `pul_en` for that channel is 0.
- R9: With `cont` at 0, a channel turns itself off after one result. With `cont` at 1, it stays active, and the following four edges produce a new result.
- R10: Edges on an input whose channel is not active are ignored: they produce no result, no status bit and no stored sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Lets the shared counter advance |
| sig_in | input | 3 | Asynchronous inputs under measurement, one per channel |
| start | input | 3 | Per-channel start pulse |
| stop | input | 3 | Per-channel stop pulse |
| inv | input | 3 | Per-channel inversion of edge roles |
| cont | input | 3 | Per-channel continuous mode (0 = one-shot) |
| per_en | input | 3 | Per-channel period reporting enable |
| pul_en | input | 3 | Per-channel pulse reporting enable |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-1-to-clear mask for `irq_sts` |
| ts_now | output | CW | Shared timestamp counter |
| chan_on | output | 3 | Channel active flags |
| irq_sts | output | 3 | Sticky per-channel completion status |
| busy_err | output | 1 | Start rejected because the channel was already active |
| res_valid | output | 1 | One-cycle report strobe |
| res_ch | output | 2 | Channel being reported |
| res_period | output | CW | Reported period in counter ticks |
| res_pulse | output | CW | Reported pulse width in counter ticks |

## Verification
The bench goes after the four subtraction pairings: random edge spacings are applied with each first-edge polarity and each inversion setting. A design that chose the wrong pair would report a value built from the wrong intervals. Two channels finishing in the same cycle check the report ordering; a design without the priority would report the higher channel first or drop a report. Continuous mode is checked across the wrap from the fourth sample to the next first sample; a design that failed to reset the sample index would measure across two windows. A stop in the middle of a window followed by a restart checks that stale samples are discarded rather than mixed into the new result.

// File: rtl/pulse_period_capture.sv
module pulse_period_capture #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_en,
  input  logic [2:0]    sig_in,
  input  logic [2:0]    start,
  input  logic [2:0]    stop,
  input  logic [2:0]    inv,
  input  logic [2:0]    cont,
  input  logic [2:0]    per_en,
  input  logic [2:0]    pul_en,
  input  logic          clr_wr,
  input  logic [2:0]    clr_mask,
  output logic [CW-1:0] ts_now,
  output logic [2:0]    chan_on,
  output logic [2:0]    irq_sts,
  output logic          busy_err,
  output logic          res_valid,
  output logic [1:0]    res_ch,
  output logic [CW-1:0] res_period,
  output logic [CW-1:0] res_pulse
);
  localparam int NCH = 3;

  logic [NCH-1:0] s1, s2, s3, edg, done, rep, cand, clrm, pick_oh, ffall;
  logic [1:0]     idx [NCH];
  logic [CW-1:0]  t0 [NCH], t1 [NCH], t2 [NCH];
  logic [CW-1:0]  per_q [NCH], pul_q [NCH], per_c [NCH], pul_c [NCH];
  logic [1:0]     pk;
  logic           pv;

  assign edg  = s2 ^ s3;
  assign clrm = clr_wr ? clr_mask : '0;
  assign cand = irq_sts & ~rep;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_a;
    assign sel_a    = (ffall[c] == inv[c]);
    assign done[c]  = chan_on[c] & edg[c] & ~stop[c] & (idx[c] == 2'd3);
    assign per_c[c] = sel_a ? (t2[c] - t0[c]) : (ts_now - t1[c]);
    assign pul_c[c] = sel_a ? (t1[c] - t0[c]) : (t2[c] - t1[c]);
  end

  always_comb begin
    pk = 2'd0;
    pv = 1'b0;
    if (cand[0]) begin
      pk = 2'd0; pv = 1'b1;
    end else if (cand[1]) begin
      pk = 2'd1; pv = 1'b1;
    end else if (cand[2]) begin
      pk = 2'd2; pv = 1'b1;
    end
  end

  assign pick_oh = pv ? (3'b001 << pk) : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1         <= '0;
      s2         <= '0;
      s3         <= '0;
      ts_now     <= '0;
      chan_on    <= '0;
      irq_sts    <= '0;
      rep        <= '0;
      ffall      <= '0;
      busy_err   <= 1'b0;
      res_valid  <= 1'b0;
      res_ch     <= '0;
      res_period <= '0;
      res_pulse  <= '0;
      for (int c = 0; c < NCH; c++) begin
        idx[c]   <= '0;
        t0[c]    <= '0;
        t1[c]    <= '0;
        t2[c]    <= '0;
        per_q[c] <= '0;
        pul_q[c] <= '0;
      end
    end else begin
      s1 <= sig_in;
      s2 <= s1;
      s3 <= s2;
      if (tmr_en) ts_now <= ts_now + 1'b1;
      busy_err   <= |(start & chan_on);
      irq_sts    <= (irq_sts & ~clrm) | done;
      rep        <= (rep | pick_oh) & ~done & ~clrm;
      res_valid  <= pv;
      res_ch     <= pk;
      res_period <= (pv && per_en[pk]) ? per_q[pk] : '0;
      res_pulse  <= (pv && pul_en[pk]) ? pul_q[pk] : '0;
      for (int c = 0; c < NCH; c++) begin
        if (stop[c]) begin
          chan_on[c] <= 1'b0;
        end else if (start[c] && !chan_on[c]) begin
          chan_on[c] <= 1'b1;
          idx[c]     <= 2'd0;
        end else if (chan_on[c] && edg[c]) begin
          case (idx[c])
            2'd0: begin
              t0[c]    <= ts_now;
              ffall[c] <= ~s2[c];
              idx[c]   <= 2'd1;
            end
            2'd1: begin
              t1[c]  <= ts_now;
              idx[c] <= 2'd2;
            end
            2'd2: begin
              t2[c]  <= ts_now;
              idx[c] <= 2'd3;
            end
            default: begin
              per_q[c]   <= per_c[c];
              pul_q[c]   <= pul_c[c];
              idx[c]     <= 2'd0;
              chan_on[c] <= cont[c];
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pulse_period_capture_chk.sv
module pulse_period_capture_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_en,
  input logic [2:0]    start,
  input logic [2:0]    stop,
  input logic [2:0]    per_en,
  input logic [2:0]    pul_en,
  input logic          clr_wr,
  input logic [CW-1:0] ts_now,
  input logic [2:0]    chan_on,
  input logic [2:0]    irq_sts,
  input logic          busy_err,
  input logic          res_valid,
  input logic [1:0]    res_ch,
  input logic [CW-1:0] res_period,
  input logic [CW-1:0] res_pulse
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |=> ts_now == $past(ts_now) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(ts_now));
  p_start_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start & ~stop) != 3'b0 |=> (chan_on & $past(start & ~stop)) == $past(start & ~stop));
  p_stop_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop != 3'b0 |=> (chan_on & $past(stop)) == 3'b0);
  p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> $past(start & chan_on) != 3'b0);
  p_sts_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (irq_sts & $past(irq_sts)) == $past(irq_sts));
  p_report_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(irq_sts) != 3'b0) && (res_ch != 2'd3));
  p_per_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ((($past(per_en) >> res_ch) & 3'b001) == 3'b000) |-> res_period == '0);
  p_pul_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ((($past(pul_en) >> res_ch) & 3'b001) == 3'b000) |-> res_pulse == '0);
endmodule

bind pulse_period_capture pulse_period_capture_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .start(start), .stop(stop),
  .per_en(per_en), .pul_en(pul_en), .clr_wr(clr_wr), .ts_now(ts_now),
  .chan_on(chan_on), .irq_sts(irq_sts), .busy_err(busy_err),
  .res_valid(res_valid), .res_ch(res_ch), .res_period(res_period),
  .res_pulse(res_pulse)
);

// File: tb/tb_pulse_period_capture.sv
module tb_pulse_period_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0;
  logic [2:0] sig_in = '0, start = '0, stop = '0, inv = '0, cont = '0;
  logic [2:0] per_en = '1, pul_en = '1, clr_mask = '0;
  logic clr_wr = 1'b0;
  logic [31:0] ts_now, res_period, res_pulse;
  logic [2:0] chan_on, irq_sts;
  logic busy_err, res_valid;
  logic [1:0] res_ch;
  int vecs = 0, errs = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  pulse_period_capture dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .sig_in(sig_in), .start(start),
    .stop(stop), .inv(inv), .cont(cont), .per_en(per_en), .pul_en(pul_en),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .ts_now(ts_now), .chan_on(chan_on),
    .irq_sts(irq_sts), .busy_err(busy_err), .res_valid(res_valid),
    .res_ch(res_ch), .res_period(res_period), .res_pulse(res_pulse)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep_start(input logic [2:0] m, input bit lvl);
    sig_in = lvl ? (sig_in | m) : (sig_in & ~m);
    tick(5);
    start = m;
    tick(1);
    start = '0;
    tick(3);
  endtask

  task automatic edges4(input logic [2:0] m, input int a, input int b, input int c);
    sig_in ^= m; tick(a);
    sig_in ^= m; tick(b);
    sig_in ^= m; tick(c);
    sig_in ^= m;
  endtask

  task automatic wait_res(output bit got);
    got = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (res_valid) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic clr(input logic [2:0] m);
    clr_wr = 1'b1; clr_mask = m;
    tick(1);
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  function automatic logic [63:0] exp_pp(input bit lvl0, input bit iv,
                                         input int a, input int b, input int c);
    bit sel_a;
    sel_a = (!lvl0) ^ iv;
    if (sel_a) return {32'(a + b), 32'(a)};
    return {32'(b + c), 32'(b)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    bit got;
    logic [63:0] e;
    logic [31:0] v;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(ts_now == 0, "R1 reset count", ts_now, 0);
    chk(chan_on == 0 && irq_sts == 0, "R6 reset state", {chan_on, irq_sts}, 0);
    chk(!res_valid && !busy_err, "R7 reset strobes", {res_valid, busy_err}, 0);
    tick(3);
    chk(ts_now == 0, "R1 hold while disabled", ts_now, 0);
    tmr_en = 1'b1;
    tick(1);
    v = ts_now;
    tick(1);
    chk(ts_now == v + 1, "R1 step", ts_now, v + 1);
    tmr_en = 1'b0;
    v = ts_now;
    tick(4);
    chk(ts_now == v, "R1 hold mid-run", ts_now, v);
    tmr_en = 1'b1;

    // R10: edges on an idle channel produce nothing
    got = 0;
    for (int i = 0; i < 6; i++) begin
      sig_in[0] = ~sig_in[0];
      tick(5);
      if (res_valid) got = 1;
    end
    chk(!got, "R10 idle edges report", got, 0);
    chk(irq_sts == 0, "R10 idle edges status", irq_sts, 0);

    // R2: stop mid-window, restart discards stale samples
    inv = '0; cont = '0; per_en = '1; pul_en = '1;
    prep_start(3'b001, 1'b0);
    chk(chan_on[0], "R2 start", chan_on[0], 1);
    sig_in[0] = 1'b1; tick(6);
    sig_in[0] = 1'b0; tick(6);
    stop = 3'b001; start = 3'b001;
    tick(1);
    stop = '0; start = '0;
    chk(!chan_on[0], "R2 stop wins", chan_on[0], 0);
    sig_in[0] = 1'b1; tick(6);
    sig_in[0] = 1'b0; tick(6);
    prep_start(3'b001, 1'b0);
    edges4(3'b001, 5, 9, 13);
    wait_res(got);
    chk(got && res_ch == 0, "R2 restart result", res_ch, 0);
    chk(res_period == 14, "R2 restart period", res_period, 14);
    chk(res_pulse == 5, "R4 restart pulse", res_pulse, 5);
    clr(3'b001);

    // R7: two channels completing together, lowest first
    prep_start(3'b101, 1'b1);
    edges4(3'b101, 6, 10, 15);
    wait_res(got);
    chk(got && res_ch == 0, "R7 first report ch0", res_ch, 0);
    chk(res_period == 25 && res_pulse == 10, "R4 falling-first", res_period, 25);
    tick(1);
    chk(res_valid && res_ch == 2, "R7 second report ch2", res_ch, 2);
    chk(res_period == 25 && res_pulse == 10, "R4 ch2 values", res_pulse, 10);
    tick(1);
    chk(!res_valid, "R7 reported once", res_valid, 0);
    clr(3'b000);
    chk(irq_sts == 3'b101, "R6 zero mask keeps", irq_sts, 5);
    clr(3'b001);
    chk(irq_sts == 3'b100, "R6 partial clear", irq_sts, 4);
    clr(3'b100);
    chk(irq_sts == 0, "R6 full clear", irq_sts, 0);

    // R9 / R3: continuous channel keeps running, restart is rejected
    cont[1] = 1'b1; inv[1] = 1'b1;
    prep_start(3'b010, 1'b1);
    edges4(3'b010, 7, 11, 4);
    wait_res(got);
    chk(got && res_ch == 1, "R9 cont first result", res_ch, 1);
    chk(res_period == 18 && res_pulse == 7, "R5 inverted falling-first", res_period, 18);
    chk(chan_on[1], "R9 cont stays active", chan_on[1], 1);
    start = 3'b010;
    tick(1);
    start = '0;
    chk(busy_err, "R3 busy raised", busy_err, 1);
    tick(1);
    chk(!busy_err, "R3 busy one cycle", busy_err, 0);
    chk(chan_on[1], "R3 state kept", chan_on[1], 1);
    edges4(3'b010, 6, 8, 10);
    wait_res(got);
    chk(got && res_ch == 1, "R9 cont second result", res_ch, 1);
    chk(res_period == 14 && res_pulse == 6, "R9 second window", res_period, 14);
    stop = 3'b010;
    tick(1);
    stop = '0; cont[1] = 1'b0;
    clr(3'b111);

    // Random measurements, one-shot
    for (int it = 0; it < 40; it++) begin
      int ch, a, b, c;
      bit lvl;
      logic [2:0] m;
      ch = int'($urandom % 3);
      m = 3'b001 << ch;
      lvl = 1'($urandom % 2);
      inv[ch] = 1'($urandom % 2);
      per_en[ch] = 1'($urandom % 2);
      pul_en[ch] = 1'($urandom % 2);
      a = 3 + int'($urandom % 38);
      b = 3 + int'($urandom % 38);
      c = 3 + int'($urandom % 38);
      e = exp_pp(lvl, inv[ch], a, b, c);
      prep_start(m, lvl);
      chk(chan_on[ch], "R2 random start", chan_on[ch], 1);
      edges4(m, a, b, c);
      wait_res(got);
      chk(got && res_ch == 2'(ch), "R7 random report", res_ch, ch);
      chk(res_period == (per_en[ch] ? e[63:32] : 32'd0),
          inv[ch] ? "R5 period (R8 mask)" : "R4 period (R8 mask)",
          res_period, per_en[ch] ? e[63:32] : 0);
      chk(res_pulse == (pul_en[ch] ? e[31:0] : 32'd0),
          inv[ch] ? "R5 pulse (R8 mask)" : "R4 pulse (R8 mask)",
          res_pulse, pul_en[ch] ? e[31:0] : 0);
      chk(irq_sts[ch], "R6 status set", irq_sts[ch], 1);
      chk(!chan_on[ch], "R9 one-shot off", chan_on[ch], 0);
      clr(m);
      chk(irq_sts == 0, "R6 cleared", irq_sts, 0);
    end

    finish_up();
  end
endmodule